// File: doc/BRIEF.md
# Coarse-Grained Hardware Thread Context Scheduler

This block decides which of several resident hardware threads (contexts) feeds a single-issue pipeline. Every context owns a program counter inside the block and a register bank selected by the block, so moving from one thread to another needs no save or restore of state through memory. The running context keeps the pipeline until it issues a memory request marked with a switch flag. The scheduler then parks that context as waiting and hands the pipeline to the next ready context.

A waiting context becomes ready again when its own completion line pulses. Contexts are searched round-robin, starting with the one after the context now holding the pipeline. When no context is ready, the block raises an idle output and ignores issue-side inputs. It leaves idle as soon as some context is ready. The pipeline drives a PC-advance strobe with the next PC value, which updates the program counter of the running context only.

Top module: `ctx_sched`

## Requirements
- R1: After reset, context 0 holds the pipeline at PC 0, `idle_o` is 0 and `bank_sel_o` is 4'b0001. Every other context is ready at its configured start PC (defaults: context 1 at 0x100, context 2 at 0x200, context 3 at 0x300).
- R2: A request with `mem_req_i`=1 and `mem_swap_i`=1 while not idle moves `cur_ctx_o`, on the next clock edge, to the first ready context found searching upward from the current index plus one, wrapping around.
- R3: A request with `mem_req_i`=1 and `mem_swap_i`=0 leaves the running context unchanged.
- R4: A context that switched out is never selected again until its bit of `done_i` has pulsed.
- R5: A pulse on `done_i[k]` while context k is waiting makes it ready at the next edge. The context can be selected from the edge after that.
- R6: When a switch finds no ready context, `idle_o` goes to 1 at the next edge and `cur_ctx_o` keeps its value. While idle, `mem_req_i` and `pc_adv_i` have no effect.
- R7: While idle, the first ready context found by the round-robin search is selected at the next edge, and `idle_o` returns to 0.
- R8: `pc_adv_i`=1 while not idle writes `pc_nxt_i` into the running context's PC. Each context's PC is kept across switches, and `cur_pc_o` shows the PC of `cur_ctx_o`.
- R9: `bank_sel_o` is the one-hot decode of `cur_ctx_o` while not idle, and all zeros while idle.
- R10: A `done_i` pulse for a context that is not waiting is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mem_req_i | input | 1 | Memory request strobe from the running context |
| mem_swap_i | input | 1 | Switch flag qualifying `mem_req_i` |
| done_i | input | NUM_CTX | Per-context memory completion pulses |
| pc_adv_i | input | 1 | Advance strobe for the running context's PC |
| pc_nxt_i | input | PC_W | New PC value written on `pc_adv_i` |
| cur_ctx_o | output | $clog2(NUM_CTX) | Index of the context holding the pipeline |
| cur_pc_o | output | PC_W | Program counter of `cur_ctx_o` |
| idle_o | output | 1 | No context is ready, so nothing issues |
| bank_sel_o | output | NUM_CTX | One-hot register bank select |

## Verification
All results are registered once. A switch request, a PC advance or a pick out of idle therefore shows up at the outputs after exactly one clock edge. A completion pulse needs two edges before the context can appear on `cur_ctx_o`: one edge makes it ready, the next selects it. The bench drives each vector on the falling edge and compares the outputs at the following falling edge, one full edge later. The vector table includes steps in which a completion has arrived but idle is still expected to hold, which checks that the two-edge delay is respected.

// File: rtl/ctx_sched_pkg.sv
package ctx_sched_pkg;

    typedef enum logic [1:0] {
        CTX_READY = 2'd0,
        CTX_RUN   = 2'd1,
        CTX_WAIT  = 2'd2
    } ctx_state_e;

endpackage

// File: rtl/ctx_rr_pick.sv
module ctx_rr_pick #(
    parameter int NUM_CTX = 4,
    localparam int IDX_W  = $clog2(NUM_CTX)
) (
    input  logic [NUM_CTX-1:0] req_i,
    input  logic [IDX_W-1:0]   base_i,
    output logic               found_o,
    output logic [IDX_W-1:0]   idx_o
);

    // Search starts one past base_i and wraps; base_i itself is tried last.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        for (int k = 1; k <= NUM_CTX; k++) begin
            int j;
            j = (int'(base_i) + k) % NUM_CTX;
            if (!found_o && req_i[j]) begin
                found_o = 1'b1;
                idx_o   = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/ctx_pc_bank.sv
module ctx_pc_bank #(
    parameter int NUM_CTX                       = 4,
    parameter int PC_W                          = 32,
    parameter logic [NUM_CTX*PC_W-1:0] START_PCS = '0,
    localparam int IDX_W                        = $clog2(NUM_CTX)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  logic [PC_W-1:0]  wr_pc_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic [PC_W-1:0]  rd_pc_o
);

    logic [PC_W-1:0] pc_d [NUM_CTX];
    logic [PC_W-1:0] pc_q [NUM_CTX];

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_pc
        // Context 0 always boots at address zero.
        localparam logic [PC_W-1:0] RST_PC = (g == 0) ? '0 : START_PCS[g*PC_W +: PC_W];

        always_comb begin
            pc_d[g] = pc_q[g];
            if (wr_en_i && (wr_idx_i == IDX_W'(g))) begin
                pc_d[g] = wr_pc_i;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pc_q[g] <= RST_PC;
            end else begin
                pc_q[g] <= pc_d[g];
            end
        end
    end

    assign rd_pc_o = pc_q[rd_idx_i];

endmodule

// File: rtl/ctx_bank_dec.sv
module ctx_bank_dec #(
    parameter int NUM_CTX = 4,
    localparam int IDX_W  = $clog2(NUM_CTX)
) (
    input  logic               en_i,
    input  logic [IDX_W-1:0]   idx_i,
    output logic [NUM_CTX-1:0] sel_o
);

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_sel
        assign sel_o[g] = en_i && (idx_i == IDX_W'(g));
    end

endmodule

// File: rtl/ctx_sched.sv
module ctx_sched
    import ctx_sched_pkg::*;
#(
    parameter int NUM_CTX                        = 4,
    parameter int PC_W                           = 32,
    parameter logic [NUM_CTX*PC_W-1:0] START_PCS = {32'h300, 32'h200, 32'h100, 32'h0},
    localparam int IDX_W                         = $clog2(NUM_CTX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mem_req_i,
    input  logic               mem_swap_i,
    input  logic [NUM_CTX-1:0] done_i,
    input  logic               pc_adv_i,
    input  logic [PC_W-1:0]    pc_nxt_i,
    output logic [IDX_W-1:0]   cur_ctx_o,
    output logic [PC_W-1:0]    cur_pc_o,
    output logic               idle_o,
    output logic [NUM_CTX-1:0] bank_sel_o
);

    typedef struct packed {
        ctx_state_e [NUM_CTX-1:0] st;
        logic [IDX_W-1:0]         cur;
        logic                     idle;
    } sched_t;

    sched_t s_d, s_q;

    logic [NUM_CTX-1:0] ready_vec;
    logic               pick_found;
    logic [IDX_W-1:0]   pick_idx;
    logic               swap_go;

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_rdy
        assign ready_vec[g] = (s_q.st[g] == CTX_READY);
    end

    ctx_rr_pick #(.NUM_CTX(NUM_CTX)) u_pick (
        .req_i   (ready_vec),
        .base_i  (s_q.cur),
        .found_o (pick_found),
        .idx_o   (pick_idx)
    );

    assign swap_go = !s_q.idle && mem_req_i && mem_swap_i;

    always_comb begin
        s_d = s_q;
        // Completions only wake contexts that are parked.
        for (int i = 0; i < NUM_CTX; i++) begin
            if (s_q.st[i] == CTX_WAIT && done_i[i]) begin
                s_d.st[i] = CTX_READY;
            end
        end
        if (swap_go) begin
            s_d.st[s_q.cur] = CTX_WAIT;
            if (pick_found) begin
                s_d.cur           = pick_idx;
                s_d.st[pick_idx]  = CTX_RUN;
            end else begin
                s_d.idle = 1'b1;
            end
        end else if (s_q.idle && pick_found) begin
            s_d.cur          = pick_idx;
            s_d.st[pick_idx] = CTX_RUN;
            s_d.idle         = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cur  <= '0;
            s_q.idle <= 1'b0;
            for (int i = 0; i < NUM_CTX; i++) begin
                if (i == 0) s_q.st[i] <= CTX_RUN;
                else        s_q.st[i] <= CTX_READY;
            end
        end else begin
            s_q <= s_d;
        end
    end

    ctx_pc_bank #(
        .NUM_CTX   (NUM_CTX),
        .PC_W      (PC_W),
        .START_PCS (START_PCS)
    ) u_pcs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en_i  (pc_adv_i && !s_q.idle),
        .wr_idx_i (s_q.cur),
        .wr_pc_i  (pc_nxt_i),
        .rd_idx_i (s_q.cur),
        .rd_pc_o  (cur_pc_o)
    );

    ctx_bank_dec #(.NUM_CTX(NUM_CTX)) u_dec (
        .en_i  (!s_q.idle),
        .idx_i (s_q.cur),
        .sel_o (bank_sel_o)
    );

    assign cur_ctx_o = s_q.cur;
    assign idle_o    = s_q.idle;

endmodule

// File: rtl/ctx_sched_chk.sv
module ctx_sched_chk #(
    parameter int NUM_CTX = 4,
    parameter int PC_W    = 32,
    localparam int IDX_W  = $clog2(NUM_CTX)
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mem_req_i,
    input logic               mem_swap_i,
    input logic               pc_adv_i,
    input logic [PC_W-1:0]    pc_nxt_i,
    input logic [IDX_W-1:0]   cur_ctx_o,
    input logic [PC_W-1:0]    cur_pc_o,
    input logic               idle_o,
    input logic [NUM_CTX-1:0] bank_sel_o
);

    // R2
    swap_moves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_i && mem_swap_i && !idle_o) |=> (idle_o || (cur_ctx_o != $past(cur_ctx_o))));

    // R3
    noswap_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_i && !mem_swap_i && !idle_o) |=> (!idle_o && $stable(cur_ctx_o)));

    // R6
    idle_holds_ctx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idle_o |=> (!idle_o || $stable(cur_ctx_o)));

    // R8
    pc_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_adv_i && !idle_o && !(mem_req_i && mem_swap_i)) |=> (cur_pc_o == $past(pc_nxt_i)));

    // R9
    bank_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(bank_sel_o) == (idle_o ? 0 : 1));

endmodule

bind ctx_sched ctx_sched_chk #(.NUM_CTX(NUM_CTX), .PC_W(PC_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mem_req_i  (mem_req_i),
    .mem_swap_i (mem_swap_i),
    .pc_adv_i   (pc_adv_i),
    .pc_nxt_i   (pc_nxt_i),
    .cur_ctx_o  (cur_ctx_o),
    .cur_pc_o   (cur_pc_o),
    .idle_o     (idle_o),
    .bank_sel_o (bank_sel_o)
);

// File: tb/test_ctx_sched.sv
module test_ctx_sched;

    localparam int NV = 15;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        mem_req_i, mem_swap_i, pc_adv_i;
    logic [3:0]  done_i;
    logic [31:0] pc_nxt_i;
    logic [1:0]  cur_ctx_o;
    logic [31:0] cur_pc_o;
    logic        idle_o;
    logic [3:0]  bank_sel_o;

    int errors = 0;
    int checks = 0;

    ctx_sched i_ctx_sched (
        .clk        (clk),
        .rst_n      (rst_n),
        .mem_req_i  (mem_req_i),
        .mem_swap_i (mem_swap_i),
        .done_i     (done_i),
        .pc_adv_i   (pc_adv_i),
        .pc_nxt_i   (pc_nxt_i),
        .cur_ctx_o  (cur_ctx_o),
        .cur_pc_o   (cur_pc_o),
        .idle_o     (idle_o),
        .bank_sel_o (bank_sel_o)
    );

    always #2 clk = ~clk;

    // Stimulus: {req, swap, done[3:0], adv, nxt[15:0]}
    localparam logic [22:0] STIM [NV] = '{
        {1'b0, 1'b0, 4'b0000, 1'b1, 16'h0004},  // 0  R8 advance ctx0
        {1'b1, 1'b0, 4'b0000, 1'b1, 16'h0008},  // 1  R3 no-swap request
        {1'b1, 1'b1, 4'b0000, 1'b1, 16'h000C},  // 2  R2 swap 0->1
        {1'b0, 1'b0, 4'b0100, 1'b1, 16'h0104},  // 3  R10 done for ready ctx2
        {1'b1, 1'b1, 4'b0000, 1'b0, 16'h0000},  // 4  R2 swap 1->2
        {1'b1, 1'b1, 4'b0000, 1'b0, 16'h0000},  // 5  R4 swap 2->3 skipping waiters
        {1'b1, 1'b1, 4'b0000, 1'b0, 16'h0000},  // 6  R6 none ready -> idle
        {1'b1, 1'b1, 4'b0000, 1'b1, 16'h0999},  // 7  R6 ignored while idle
        {1'b0, 1'b0, 4'b0010, 1'b0, 16'h0000},  // 8  R5 ctx1 wakes, still idle
        {1'b0, 1'b0, 4'b0000, 1'b0, 16'h0000},  // 9  R7 ctx1 picked, R8 pc kept
        {1'b0, 1'b0, 4'b0101, 1'b0, 16'h0000},  // 10 R5 ctx0, ctx2 wake
        {1'b1, 1'b1, 4'b0000, 1'b0, 16'h0000},  // 11 R2 after 1 comes 2
        {1'b1, 1'b1, 4'b0000, 1'b0, 16'h0000},  // 12 R2 wrap to 0
        {1'b0, 1'b0, 4'b1000, 1'b0, 16'h0000},  // 13 R5 ctx3 wakes
        {1'b1, 1'b1, 4'b0000, 1'b0, 16'h0000}   // 14 R2 after 0 skip waiters to 3
    };

    // Expected after the edge: {idle, ctx[1:0], pc[15:0]}
    localparam logic [18:0] EXPV [NV] = '{
        {1'b0, 2'd0, 16'h0004},
        {1'b0, 2'd0, 16'h0008},
        {1'b0, 2'd1, 16'h0100},
        {1'b0, 2'd1, 16'h0104},
        {1'b0, 2'd2, 16'h0200},
        {1'b0, 2'd3, 16'h0300},
        {1'b1, 2'd3, 16'h0300},
        {1'b1, 2'd3, 16'h0300},
        {1'b1, 2'd3, 16'h0300},
        {1'b0, 2'd1, 16'h0104},
        {1'b0, 2'd1, 16'h0104},
        {1'b0, 2'd2, 16'h0200},
        {1'b0, 2'd0, 16'h000C},
        {1'b0, 2'd0, 16'h000C},
        {1'b0, 2'd3, 16'h0300}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic check_outputs(input string req, input logic idle_e,
                                 input logic [1:0] ctx_e, input logic [31:0] pc_e);
        logic [3:0] sel_e;
        sel_e = idle_e ? 4'b0000 : (4'b0001 << ctx_e);
        check({req, " idle"}, {31'd0, idle_o}, {31'd0, idle_e});
        check({req, " ctx"}, {30'd0, cur_ctx_o}, {30'd0, ctx_e});
        check({req, " pc"}, cur_pc_o, pc_e);
        check({req, " R9 bank_sel"}, {28'd0, bank_sel_o}, {28'd0, sel_e});
    endtask

    task automatic idle_inputs();
        mem_req_i  = 1'b0;
        mem_swap_i = 1'b0;
        done_i     = 4'b0000;
        pc_adv_i   = 1'b0;
        pc_nxt_i   = '0;
    endtask

    initial begin
        rst_n = 1'b0;
        idle_inputs();
        repeat (3) @(negedge clk);
        // R1 reset state
        check_outputs("R1 reset", 1'b0, 2'd0, 32'h0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            {mem_req_i, mem_swap_i, done_i, pc_adv_i} = STIM[v][22:16];
            pc_nxt_i = {16'd0, STIM[v][15:0]};
            @(negedge clk);
            check_outputs($sformatf("vector %0d", v), EXPV[v][18], EXPV[v][17:16],
                          {16'd0, EXPV[v][15:0]});
        end

        // R10 done for the running context has no effect: it must stay parked after swapping out
        idle_inputs();
        done_i = 4'b1000;
        @(negedge clk);
        idle_inputs();
        mem_req_i = 1'b1; mem_swap_i = 1'b1;      // 3 -> 0? ctx0 waits, 1 waits, 2 waits -> idle
        @(negedge clk);
        idle_inputs();
        check_outputs("R10 stray done", 1'b1, 2'd3, 32'h300);
        @(negedge clk);
        check_outputs("R10 still idle", 1'b1, 2'd3, 32'h300);

        // R1 reset in mid-run restores context 0 at PC 0
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check_outputs("R1 re-reset", 1'b0, 2'd0, 32'h0);
        // R1 ctx1 start address after reset
        mem_req_i = 1'b1; mem_swap_i = 1'b1;
        @(negedge clk);
        idle_inputs();
        check_outputs("R1 ctx1 start", 1'b0, 2'd1, 32'h100);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule